// File: doc/BRIEF.md
# Notification Ring Producer

This block writes short notification messages from a set of engines into circular buffers in memory. Every message carries a type code and an engine number. Together these pick one of a fixed set of queues. Each queue has a small register block on an APB-style register port. The block holds a 64-bit ring base split over two words, a ring size in bytes, and a head offset that only hardware moves.

When a message arrives for an armed queue, the block issues one 16-byte memory write at the ring base plus the current head. It then moves the head forward by one message, wrapping within the ring. A queue is armed by writing a non-zero size and halted by writing zero. Messages for a halted queue are thrown away, and a per-queue flag records each loss. Software reads the head to learn how far the producer has written. There is no doorbell, no tail register and no interrupt.

Top module: `nq_ring_producer`

## Requirements
- R1: After reset every configuration register reads zero, no memory write is pending, `msg_ready` is high and every drop flag is clear.
- R2: Queue q owns a 40-byte register block at byte address 0x100 + q*0x28. Base low is at +0x0, base high at +0x4, size at +0x8 and head at +0xC. Base and size read back what was written.
- R3: Reads of block offsets 0x10 to 0x27 return zero, and writes there change nothing. Addresses below 0x100 read zero.
- R4: The head register cannot be written by software. A write to it leaves its value unchanged.
- R5: A message with type t and engine e goes to queue t*16 + e. Types 0 to 5 and engines 0 to 15 are valid.
- R6: A queue is armed while its size is non-zero. A message accepted for an armed queue causes one memory write request in the next cycle. The address is {base high, base low} + head, and the 128-bit data is the message payload.
- R7: Each accepted message moves the head forward by 16, modulo the ring size. The ring size is a power of two and at least 16.
- R8: Writing a non-zero size sets that queue's head to zero and clears its drop flag.
- R9: A message accepted for a queue whose size is zero makes no write request. It sets bit q of `drop_flag`, and the bit stays set until the queue is armed again.
- R10: Writing size zero halts the queue, so later messages for it are dropped. A write request already issued before the halt still completes with its original address and data.
- R11: A write request holds `mem_req`, `mem_addr` and `mem_data` steady until `mem_ack`, and drops `mem_req` in the cycle after the acknowledge. `msg_ready` stays low while a request is pending.
- R12: A message whose type is 6 or above, or whose engine is at or above the engine count, is dropped with no write request and no change to any drop flag.
- R13: `pready` is always high. Read data is registered in the setup phase and valid in the access phase. A write takes effect at the clock edge that ends the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write when high |
| paddr | input | ADDR_W (12) | Register byte address |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |
| pready | output | 1 | Register port ready, always high |
| msg_valid | input | 1 | Message offered |
| msg_type | input | TYPE_W (3) | Message type code |
| msg_engine | input | ENG_W (4) | Source engine number |
| msg_data | input | DATA_W (128) | Message payload |
| msg_ready | output | 1 | Message accepted when high with msg_valid |
| mem_req | output | 1 | Memory write request pending |
| mem_addr | output | 64 | Memory byte address |
| mem_data | output | DATA_W (128) | Memory write data |
| mem_ack | input | 1 | Memory write accepted |
| drop_flag | output | NQ (96) | Sticky per-queue drop flags |

## Verification
The bench uses the default parameters: six types, sixteen engine slots and a 12-bit register address. With these values the last queue, type 5 engine 15 at block 0xFD8, can be addressed at the top of the register space, and the unused type codes 6 and 7 can be driven to exercise the out-of-range drop. The rings used are 64, 32 and 16 bytes long, so head wrap-around happens within a few messages, including a ring exactly one message long. A halt is written while a request waits for its acknowledge, so the in-flight rule is tested directly.

// File: rtl/nq_pkg.sv
package nq_pkg;
  localparam int unsigned BLK_BASE   = 'h100;
  localparam int unsigned BLK_STRIDE = 'h28;
  localparam int unsigned MSG_BYTES  = 16;

  typedef enum logic [2:0] {
    F_LO   = 3'd0,
    F_HI   = 3'd1,
    F_SIZE = 3'd2,
    F_HEAD = 3'd3,
    F_NONE = 3'd4
  } field_e;
endpackage

// File: rtl/nq_apb_decode.sv
module nq_apb_decode
  import nq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NQ     = 96,
  parameter int unsigned QW     = 7
) (
  input  logic [ADDR_W-1:0] paddr,
  output logic [QW-1:0]     q,
  output field_e            fld
);
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] qfull;
  logic [ADDR_W-1:0] off;
  logic              hit;

  always_comb begin
    rel   = paddr - ADDR_W'(BLK_BASE);
    qfull = rel / ADDR_W'(BLK_STRIDE);
    off   = rel % ADDR_W'(BLK_STRIDE);
    hit   = (paddr >= ADDR_W'(BLK_BASE)) && (qfull < ADDR_W'(NQ));
    q     = qfull[QW-1:0];
    if (!hit)                    fld = F_NONE;
    else if (off < ADDR_W'(4))   fld = F_LO;
    else if (off < ADDR_W'(8))   fld = F_HI;
    else if (off < ADDR_W'(12))  fld = F_SIZE;
    else if (off < ADDR_W'(16))  fld = F_HEAD;
    else                         fld = F_NONE;
  end
endmodule

// File: rtl/nq_cfg_bank.sv
module nq_cfg_bank
  import nq_pkg::*;
#(
  parameter int unsigned NQ = 96,
  parameter int unsigned QW = 7
) (
  input  logic          clk,
  input  logic          rst,
  // software side
  input  logic          wr_en,
  input  logic [QW-1:0] sw_q,
  input  field_e        sw_fld,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  // producer side
  input  logic [QW-1:0] lk_q,
  output logic [31:0]   lk_lo,
  output logic [31:0]   lk_hi,
  output logic [31:0]   lk_size,
  output logic [31:0]   lk_head,
  input  logic          adv_en,
  input  logic          drop_en,
  output logic [NQ-1:0] drop_flag
);
  logic [31:0] lo_r   [NQ];
  logic [31:0] hi_r   [NQ];
  logic [31:0] size_r [NQ];
  logic [31:0] head_r [NQ];
  logic        arm_wr;

  assign arm_wr = wr_en && (sw_fld == F_SIZE) && (wr_data != 32'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQ; i++) begin
        lo_r[i]   <= '0;
        hi_r[i]   <= '0;
        size_r[i] <= '0;
        head_r[i] <= '0;
      end
    end else begin
      if (adv_en)
        head_r[lk_q] <= (head_r[lk_q] + 32'(MSG_BYTES)) & (size_r[lk_q] - 32'd1);
      if (wr_en) begin
        case (sw_fld)
          F_LO:   lo_r[sw_q] <= wr_data;
          F_HI:   hi_r[sw_q] <= wr_data;
          F_SIZE: begin
            size_r[sw_q] <= wr_data;
            if (wr_data != 32'd0) head_r[sw_q] <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_drop
    always_ff @(posedge clk) begin
      if (rst)
        drop_flag[g] <= 1'b0;
      else if (arm_wr && (sw_q == QW'(g)))
        drop_flag[g] <= 1'b0;
      else if (drop_en && (lk_q == QW'(g)))
        drop_flag[g] <= 1'b1;
    end
  end

  always_comb begin
    case (sw_fld)
      F_LO:    rd_data = lo_r[sw_q];
      F_HI:    rd_data = hi_r[sw_q];
      F_SIZE:  rd_data = size_r[sw_q];
      F_HEAD:  rd_data = head_r[sw_q];
      default: rd_data = '0;
    endcase
    lk_lo   = lo_r[lk_q];
    lk_hi   = hi_r[lk_q];
    lk_size = size_r[lk_q];
    lk_head = head_r[lk_q];
  end
endmodule

// File: rtl/nq_dispatch.sv
module nq_dispatch #(
  parameter int unsigned TYPE_W    = 3,
  parameter int unsigned ENG_W     = 4,
  parameter int unsigned NUM_TYPES = 6,
  parameter int unsigned NUM_ENG   = 16,
  parameter int unsigned DATA_W    = 128,
  localparam int unsigned QW       = TYPE_W + ENG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [TYPE_W-1:0] msg_type,
  input  logic [ENG_W-1:0]  msg_engine,
  input  logic [DATA_W-1:0] msg_data,
  output logic              msg_ready,
  output logic [QW-1:0]     lk_q,
  input  logic [31:0]       lk_lo,
  input  logic [31:0]       lk_hi,
  input  logic [31:0]       lk_size,
  input  logic [31:0]       lk_head,
  output logic              adv_en,
  output logic              drop_en,
  output logic              mem_req,
  output logic [63:0]       mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack
);
  logic in_range;
  logic take;

  always_comb begin
    lk_q     = {msg_type, msg_engine};
    in_range = ({1'b0, msg_type} < (TYPE_W+1)'(NUM_TYPES)) &&
               ({1'b0, msg_engine} < (ENG_W+1)'(NUM_ENG));
    take     = msg_valid && msg_ready;
    adv_en   = take && in_range && (lk_size != 32'd0);
    drop_en  = take && in_range && (lk_size == 32'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      msg_ready <= 1'b1;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (mem_req) begin
      if (mem_ack) begin
        mem_req   <= 1'b0;
        msg_ready <= 1'b1;
      end
    end else if (adv_en) begin
      mem_req   <= 1'b1;
      msg_ready <= 1'b0;
      mem_addr  <= {lk_hi, lk_lo} + {32'd0, lk_head};
      mem_data  <= msg_data;
    end
  end
endmodule

// File: rtl/nq_ring_producer.sv
module nq_ring_producer
  import nq_pkg::*;
#(
  parameter int unsigned NUM_TYPES = 6,
  parameter int unsigned NUM_ENG   = 16,
  parameter int unsigned ENG_SLOTS = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 128,
  localparam int unsigned TYPE_W   = $clog2(NUM_TYPES),
  localparam int unsigned ENG_W    = $clog2(ENG_SLOTS),
  localparam int unsigned QW       = TYPE_W + ENG_W,
  localparam int unsigned NQ       = NUM_TYPES * ENG_SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              msg_valid,
  input  logic [TYPE_W-1:0] msg_type,
  input  logic [ENG_W-1:0]  msg_engine,
  input  logic [DATA_W-1:0] msg_data,
  output logic              msg_ready,
  output logic              mem_req,
  output logic [63:0]       mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack,
  output logic [NQ-1:0]     drop_flag
);
  logic [QW-1:0] sw_q;
  field_e        sw_fld;
  logic [31:0]   rd_data;
  logic [QW-1:0] lk_q;
  logic [31:0]   lk_lo, lk_hi, lk_size, lk_head;
  logic          adv_en, drop_en;

  assign pready = 1'b1;

  nq_apb_decode #(.ADDR_W(ADDR_W), .NQ(NQ), .QW(QW)) u_dec (
    .paddr (paddr),
    .q     (sw_q),
    .fld   (sw_fld)
  );

  nq_cfg_bank #(.NQ(NQ), .QW(QW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (psel && penable && pwrite),
    .sw_q      (sw_q),
    .sw_fld    (sw_fld),
    .wr_data   (pwdata),
    .rd_data   (rd_data),
    .lk_q      (lk_q),
    .lk_lo     (lk_lo),
    .lk_hi     (lk_hi),
    .lk_size   (lk_size),
    .lk_head   (lk_head),
    .adv_en    (adv_en),
    .drop_en   (drop_en),
    .drop_flag (drop_flag)
  );

  nq_dispatch #(
    .TYPE_W(TYPE_W), .ENG_W(ENG_W), .NUM_TYPES(NUM_TYPES),
    .NUM_ENG(NUM_ENG), .DATA_W(DATA_W)
  ) u_disp (
    .clk        (clk),
    .rst        (rst),
    .msg_valid  (msg_valid),
    .msg_type   (msg_type),
    .msg_engine (msg_engine),
    .msg_data   (msg_data),
    .msg_ready  (msg_ready),
    .lk_q       (lk_q),
    .lk_lo      (lk_lo),
    .lk_hi      (lk_hi),
    .lk_size    (lk_size),
    .lk_head    (lk_head),
    .adv_en     (adv_en),
    .drop_en    (drop_en),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .mem_ack    (mem_ack)
  );

  always_ff @(posedge clk) begin
    if (rst)
      prdata <= '0;
    else if (psel && !penable && !pwrite)
      prdata <= rd_data;
  end
endmodule

// File: rtl/nq_ring_producer_chk.sv
module nq_ring_producer_chk #(
  parameter int unsigned NQ     = 96,
  parameter int unsigned DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic              mem_req,
  input logic [63:0]       mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              mem_ack,
  input logic [NQ-1:0]     drop_flag
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  // R11
  req_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);

  // R11
  ready_block_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !msg_ready);

  // R6
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(msg_valid && msg_ready));

  // R9
  drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !(msg_valid && msg_ready) |=> ((drop_flag & ~$past(drop_flag)) == '0));
endmodule

bind nq_ring_producer nq_ring_producer_chk #(.NQ(NQ), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_ack   (mem_ack),
  .drop_flag (drop_flag)
);

// File: tb/sim_nq_ring_producer.sv
module sim_nq_ring_producer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]  paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [31:0]  prdata;
  logic         pready;
  logic         msg_valid = 1'b0;
  logic [2:0]   msg_type = '0;
  logic [3:0]   msg_engine = '0;
  logic [127:0] msg_data = '0;
  logic         msg_ready;
  logic         mem_req;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         mem_ack = 1'b0;
  logic [95:0]  drop_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  nq_ring_producer u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_engine(msg_engine),
    .msg_data(msg_data), .msg_ready(msg_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
    .drop_flag(drop_flag)
  );

  localparam logic [63:0] BASE_A = 64'h0000_0012_3400_0000;
  localparam logic [63:0] BASE_B = 64'h0000_ABCD_1000_0000;
  localparam logic [11:0] BLK_A  = 12'h3F8;  // type 1, engine 3 -> queue 19
  localparam logic [11:0] BLK_B  = 12'hFD8;  // type 5, engine 15 -> queue 95
  localparam logic [11:0] BLK_C  = 12'h718;  // type 2, engine 7 -> queue 39

  // {type[2:0], engine[3:0], expected head before the message[7:0]}
  localparam logic [14:0] VEC [0:7] = '{
    {3'd1, 4'd3,  8'd0},  {3'd1, 4'd3,  8'd16}, {3'd5, 4'd15, 8'd0},
    {3'd1, 4'd3,  8'd32}, {3'd5, 4'd15, 8'd16}, {3'd1, 4'd3,  8'd48},
    {3'd5, 4'd15, 8'd0},  {3'd1, 4'd3,  8'd0}
  };

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    apb_rd(a, v);
    check(tag, {96'd0, v}, {96'd0, exp});
  endtask

  task automatic arm(logic [11:0] blk, logic [63:0] base, logic [31:0] size);
    apb_wr(blk + 12'h4, base[63:32]);
    apb_wr(blk, base[31:0]);
    apb_wr(blk + 12'h8, size);
  endtask

  task automatic send(logic [2:0] t, logic [3:0] e, logic [127:0] d);
    @(negedge clk);
    msg_valid = 1'b1; msg_type = t; msg_engine = e; msg_data = d;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic ack_req(string tag);
    mem_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_ack = 1'b0;
    check({tag, " req released"}, {127'd0, mem_req}, 128'd0);
    check({tag, " ready back"}, {127'd0, msg_ready}, 128'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] pay;
    logic [63:0]  hold_addr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 mem_req", {127'd0, mem_req}, 128'd0);
    check("R1 msg_ready", {127'd0, msg_ready}, 128'd1);
    check("R1 drop_flag", {32'd0, drop_flag}, 128'd0);
    check("R13 pready", {127'd0, pready}, 128'd1);
    rd_check("R1 size reg", BLK_A + 12'h8, 32'd0);
    rd_check("R1 base lo reg", BLK_B, 32'd0);

    // R2 register map and read back
    arm(BLK_A, BASE_A, 32'd64);
    arm(BLK_B, BASE_B, 32'd32);
    rd_check("R2 lo A", BLK_A, BASE_A[31:0]);
    rd_check("R2 hi A", BLK_A + 12'h4, BASE_A[63:32]);
    rd_check("R2 size A", BLK_A + 12'h8, 32'd64);
    rd_check("R2 hi B", BLK_B + 12'h4, BASE_B[63:32]);
    rd_check("R2 size B", BLK_B + 12'h8, 32'd32);
    rd_check("R2 head A", BLK_A + 12'hC, 32'd0);

    // R5 R6 R7 table walk
    for (int i = 0; i < 8; i++) begin
      logic [63:0] base;
      base = (VEC[i][14:12] == 3'd1) ? BASE_A : BASE_B;
      pay  = {32'hC0DE_0000 + 32'(i), 96'h1234_5678_9ABC_DEF0_0F0F_0F0F};
      send(VEC[i][14:12], VEC[i][11:8], pay);
      check($sformatf("R6 req vec%0d", i), {127'd0, mem_req}, 128'd1);
      check($sformatf("R7 addr vec%0d", i), {64'd0, mem_addr},
            {64'd0, base + {56'd0, VEC[i][7:0]}});
      check($sformatf("R6 data vec%0d", i), mem_data, pay);
      ack_req("R11 table");
    end
    rd_check("R7 head A wrapped", BLK_A + 12'hC, 32'd16);
    rd_check("R7 head B wrapped", BLK_B + 12'hC, 32'd16);

    // R11 hold and R10 halt with a request in flight
    pay = 128'hFEED;
    send(3'd1, 4'd3, pay);
    hold_addr = mem_addr;
    check("R6 in-flight addr", {64'd0, mem_addr}, {64'd0, BASE_A + 64'd16});
    apb_wr(BLK_A + 12'h8, 32'd0);
    apb_wr(BLK_A, 32'd0);
    apb_wr(BLK_A + 12'h4, 32'd0);
    check("R11 held req", {127'd0, mem_req}, 128'd1);
    check("R11 ready low", {127'd0, msg_ready}, 128'd0);
    check("R10 in-flight addr kept", {64'd0, mem_addr}, {64'd0, hold_addr});
    check("R10 in-flight data kept", mem_data, pay);
    ack_req("R10 in-flight");

    // R10 R9 halted queue drops
    send(3'd1, 4'd3, 128'h1);
    check("R10 no req after halt", {127'd0, mem_req}, 128'd0);
    check("R9 flag 19", {127'd0, drop_flag[19]}, 128'd1);

    // R9 never-armed queue 0
    send(3'd0, 4'd0, 128'h2);
    check("R9 no req", {127'd0, mem_req}, 128'd0);
    check("R9 flags", {32'd0, drop_flag}, {32'd0, 96'h8_0001});

    // R12 type codes past the table
    send(3'd7, 4'd2, 128'h3);
    check("R12 no req t7", {127'd0, mem_req}, 128'd0);
    send(3'd6, 4'd0, 128'h4);
    check("R12 no req t6", {127'd0, mem_req}, 128'd0);
    check("R12 flags unchanged", {32'd0, drop_flag}, {32'd0, 96'h8_0001});

    // R8 rearm clears head and flag
    arm(BLK_A, BASE_A, 32'd64);
    rd_check("R8 head zero", BLK_A + 12'hC, 32'd0);
    check("R8 flag cleared", {127'd0, drop_flag[19]}, 128'd0);
    check("R8 other flag kept", {127'd0, drop_flag[0]}, 128'd1);
    send(3'd1, 4'd3, 128'h5);
    check("R8 addr after rearm", {64'd0, mem_addr}, {64'd0, BASE_A});
    ack_req("R8");

    // R3 reserved offsets and out-of-map addresses
    apb_wr(BLK_A + 12'h14, 32'hFFFF_FFFF);
    apb_wr(BLK_A + 12'h24, 32'hFFFF_FFFF);
    rd_check("R3 reserved 0x14", BLK_A + 12'h14, 32'd0);
    rd_check("R3 reserved 0x24", BLK_A + 12'h24, 32'd0);
    rd_check("R3 lo untouched", BLK_A, BASE_A[31:0]);
    rd_check("R3 size untouched", BLK_A + 12'h8, 32'd64);
    rd_check("R3 below map", 12'h0F0, 32'd0);
    rd_check("R3 reserved q95", BLK_B + 12'h10, 32'd0);

    // R4 head is read-only
    apb_wr(BLK_A + 12'hC, 32'h20);
    rd_check("R4 head unchanged", BLK_A + 12'hC, 32'd16);

    // R5 index mapping for type 2 engine 7, ring of one message
    arm(BLK_C, 64'h0000_0000_0000_5000, 32'd16);
    send(3'd2, 4'd7, 128'h6);
    check("R5 addr q39", {64'd0, mem_addr}, {64'd0, 64'h5000});
    ack_req("R5");
    send(3'd2, 4'd7, 128'h7);
    check("R7 single slot wrap", {64'd0, mem_addr}, {64'd0, 64'h5000});
    ack_req("R7");
    check("R5 no flag q39", {127'd0, drop_flag[39]}, 128'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule